// File: doc/BRIEF.md
# Two-Level Telemetry Commutator Sequencer

This block produces the channel-select timing for a pulse-amplitude-modulated telemetry frame. It runs from a slow reference clock of roughly 1.6 kHz. A divider turns that clock into one channel-time tick every `DIV` cycles, which at the default setting gives a channel time of about 0.63 s. Two rotating one-hot rings then pick the channel. The fast ring has seven bits and picks one input inside a group. The slow ring has five bits and picks one of five groups. Together they cover 35 switch positions.

The first position is the synchronisation slot. It is held for four channel times, which are numbered 36, 37, 38 and 1, and it carries a fixed level, so each frame is 38 channel times long (about 24 s). Positions 2 to 35 are then read once each.

The sequencer also marks three kinds of slot:
- the slot that carries the eight-way subcommutator, with an advance pulse at the end of that slot;
- the slots that carry the 15-bit status words, with a read strobe;
- the frame start.

A ground-command stop input freezes everything on the current channel so that channel is read out continuously. A sticky flag reports a select ring that is not one-hot.

Top module: `tlm_frame_sequencer`

## Requirements
- R1: While `rst_i` is high at a rising edge, the state returns to the first sync slot. From the next cycle on, `chan_o` is 36, `a_sel_o` and `b_sel_o` have only bit 0 set, `sync_o` is 1 and `sel_err_o` is 0. The first cycle after release shows `frame_start_o` high.
- R2: While `stop_i` is low, every channel slot lasts exactly `DIV` clock cycles. The default for `DIV` is 1024.
- R3: Data slot with channel number c (2 to 35) has position p = c-1. It drives `a_sel_o` bit (p mod 7) and `b_sel_o` bit (p div 7). Bit 0 is the first input and the first group. Channels run in rising order.
- R4: After channel 35 come four slots numbered 36, 37, 38 and 1. During these slots both selects stay at bit 0 and `sync_o` is 1. `sync_o` is 0 in every other slot, and a frame spans 38 slots.
- R5: `frame_start_o` is high for exactly one clock: the first clock of each channel-36 slot.
- R6: `subcom_adv_o` is a one-clock pulse in the last clock of the channel-18 slot. It is 0 at all other times.
- R7: `status_rd_o` is high for the whole of the channel-17 slot. It is also high for the channel-29 slot when `HAS_STATUS_B` is 1 (the default). It is 0 in every other slot.
- R8: While `stop_i` is high, the channel, the selects and the remaining slot time do not change, and `subcom_adv_o` stays 0. On release, counting resumes where it stopped.
- R9: `a_sel_o` and `b_sel_o` each have exactly one bit set. `sel_err_o` is set, and stays set until reset, when either select has none or more than one bit set. In correct operation it stays 0.
- R10: `chan_o` carries the current channel number in binary, in the range 1 to 38.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_i | input | 1 | Synchronous reset, active high |
| stop_i | input | 1 | Ground-command stop; freezes the current channel |
| a_sel_o | output | N_IN (7) | One-hot input select inside a group |
| b_sel_o | output | N_GRP (5) | One-hot group select |
| chan_o | output | CHAN_W (6) | Current channel number, 1 to 38 |
| sync_o | output | 1 | High during the held sync slots |
| frame_start_o | output | 1 | One-clock pulse at the start of channel 36 |
| subcom_adv_o | output | 1 | One-clock subcommutator advance at the end of channel 18 |
| status_rd_o | output | 1 | Status-register read strobe during channels 17 and 29 |
| sel_err_o | output | 1 | Sticky flag: a select ring is not one-hot |

## Verification
The selects, `chan_o` and `sync_o` change at the rising edge that follows the tick cycle, so a slot begins exactly `DIV` edges after the previous one and one edge after reset is released. `frame_start_o` is registered from the tick and shows in the first clock of the new slot. `subcom_adv_o` and `status_rd_o` are combinational from the current state, and `subcom_adv_o` coincides with the tick cycle itself. The bench keeps its own cycle count, which it advances only on clocks where stop is low. From that count it derives the slot and the phase within the slot, and it compares every output in the middle of each clock, between the edges. This means a stop held for any number of cycles simply moves the expected tick later.

// File: rtl/tlm_seq_pkg.sv
package tlm_seq_pkg;

    typedef enum logic {
        PH_SYNC = 1'b0,
        PH_DATA = 1'b1
    } seq_phase_e;

    // Bits needed to hold a channel number 1..total
    function automatic int unsigned chan_bits(input int unsigned total);
        return $clog2(total + 1);
    endfunction

    // Bits needed for a counter that runs 0..count-1, never less than one
    function automatic int unsigned cnt_bits(input int unsigned count);
        return (count > 1) ? $clog2(count) : 1;
    endfunction

endpackage

// File: rtl/tlm_tick_divider.sv
module tlm_tick_divider #(
    parameter int unsigned DIV = 1024
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic stop_i,
    output logic tick_o
);
    import tlm_seq_pkg::*;

    localparam int unsigned CNT_W = cnt_bits(DIV);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } div_st_t;

    div_st_t st_d, st_q;
    logic    at_end;

    always_comb begin
        st_d   = st_q;
        at_end = (st_q.cnt == CNT_W'(DIV - 1));
        tick_o = at_end & ~stop_i;
        if (!stop_i) begin
            if (at_end) begin
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/tlm_onehot_ring.sv
module tlm_onehot_ring #(
    parameter int unsigned N = 7
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic         adv_i,
    output logic [N-1:0] sel_o,
    output logic         wrap_o
);

    typedef struct packed {
        logic [N-1:0] sel;
    } ring_st_t;

    ring_st_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        wrap_o = adv_i & st_q.sel[N-1];
        if (adv_i) begin
            st_d.sel = {st_q.sel[N-2:0], st_q.sel[N-1]};
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q.sel <= N'(1);
        end else begin
            st_q <= st_d;
        end
    end

    assign sel_o = st_q.sel;

endmodule

// File: rtl/tlm_slot_decoder.sv
module tlm_slot_decoder #(
    parameter int unsigned N_IN       = 7,
    parameter int unsigned N_GRP      = 5,
    parameter int unsigned SYNC_SLOTS = 4,
    parameter int unsigned CHAN_W     = 6,
    parameter int unsigned HOLD_W     = 2
) (
    input  logic [N_IN-1:0]   a_sel_i,
    input  logic [N_GRP-1:0]  b_sel_i,
    input  logic              in_sync_i,
    input  logic [HOLD_W-1:0] hold_cnt_i,
    output logic [CHAN_W-1:0] chan_o,
    output logic              a_ok_o,
    output logic              b_ok_o
);

    localparam int unsigned DATA_CH = N_IN * N_GRP;

    logic [CHAN_W-1:0] a_idx;
    logic [CHAN_W-1:0] b_idx;

    // One-hot to binary, one OR term per ring bit
    always_comb begin
        a_idx = '0;
        for (int i = 0; i < int'(N_IN); i++) begin
            if (a_sel_i[i]) begin
                a_idx = a_idx | CHAN_W'(i);
            end
        end
    end

    always_comb begin
        b_idx = '0;
        for (int g = 0; g < int'(N_GRP); g++) begin
            if (b_sel_i[g]) begin
                b_idx = b_idx | CHAN_W'(g);
            end
        end
    end

    always_comb begin
        if (in_sync_i) begin
            if (hold_cnt_i == HOLD_W'(SYNC_SLOTS - 1)) begin
                chan_o = CHAN_W'(1);
            end else begin
                chan_o = CHAN_W'(DATA_CH + 1) + CHAN_W'(hold_cnt_i);
            end
        end else begin
            chan_o = CHAN_W'(b_idx * CHAN_W'(N_IN)) + a_idx + CHAN_W'(1);
        end
    end

    assign a_ok_o = $onehot(a_sel_i);
    assign b_ok_o = $onehot(b_sel_i);

endmodule

// File: rtl/tlm_frame_sequencer.sv
module tlm_frame_sequencer #(
    parameter int unsigned DIV          = 1024,
    parameter int unsigned N_IN         = 7,
    parameter int unsigned N_GRP        = 5,
    parameter int unsigned SYNC_SLOTS   = 4,
    parameter int unsigned SUBCOM_CH    = 18,
    parameter int unsigned STATUS_CH_A  = 17,
    parameter int unsigned STATUS_CH_B  = 29,
    parameter bit          HAS_STATUS_B = 1'b1,
    localparam int unsigned CHAN_W      = tlm_seq_pkg::chan_bits(N_IN * N_GRP + SYNC_SLOTS - 1)
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              stop_i,
    output logic [N_IN-1:0]   a_sel_o,
    output logic [N_GRP-1:0]  b_sel_o,
    output logic [CHAN_W-1:0] chan_o,
    output logic              sync_o,
    output logic              frame_start_o,
    output logic              subcom_adv_o,
    output logic              status_rd_o,
    output logic              sel_err_o
);
    import tlm_seq_pkg::*;

    localparam int unsigned HOLD_W   = cnt_bits(SYNC_SLOTS);
    localparam int unsigned FIRST_SY = N_IN * N_GRP + 1;

    typedef struct packed {
        seq_phase_e        phase;
        logic [HOLD_W-1:0] hold_cnt;
        logic              slot_first;
        logic              sel_err;
    } seq_st_t;

    seq_st_t st_d, st_q;

    logic tick;
    logic a_adv, a_wrap, b_wrap;
    logic a_ok, b_ok;
    logic hold_last, last_pos, in_sync;

    tlm_tick_divider #(.DIV(DIV)) u_div (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .stop_i (stop_i),
        .tick_o (tick)
    );

    tlm_onehot_ring #(.N(N_IN)) u_ring_a (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .adv_i  (a_adv),
        .sel_o  (a_sel_o),
        .wrap_o (a_wrap)
    );

    tlm_onehot_ring #(.N(N_GRP)) u_ring_b (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .adv_i  (a_wrap),
        .sel_o  (b_sel_o),
        .wrap_o (b_wrap)
    );

    tlm_slot_decoder #(
        .N_IN       (N_IN),
        .N_GRP      (N_GRP),
        .SYNC_SLOTS (SYNC_SLOTS),
        .CHAN_W     (CHAN_W),
        .HOLD_W     (HOLD_W)
    ) u_dec (
        .a_sel_i    (a_sel_o),
        .b_sel_i    (b_sel_o),
        .in_sync_i  (in_sync),
        .hold_cnt_i (st_q.hold_cnt),
        .chan_o     (chan_o),
        .a_ok_o     (a_ok),
        .b_ok_o     (b_ok)
    );

    always_comb begin
        st_d      = st_q;
        in_sync   = (st_q.phase == PH_SYNC);
        hold_last = (st_q.hold_cnt == HOLD_W'(SYNC_SLOTS - 1));
        last_pos  = a_sel_o[N_IN-1] & b_sel_o[N_GRP-1];
        // The first switch position is held through the sync slots
        a_adv     = tick & (~in_sync | hold_last);

        st_d.slot_first = tick;
        st_d.sel_err    = st_q.sel_err | ~a_ok | ~b_ok;

        if (tick) begin
            if (in_sync) begin
                if (hold_last) begin
                    st_d.phase    = PH_DATA;
                    st_d.hold_cnt = '0;
                end else begin
                    st_d.hold_cnt = st_q.hold_cnt + HOLD_W'(1);
                end
            end else if (last_pos) begin
                st_d.phase    = PH_SYNC;
                st_d.hold_cnt = '0;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q.phase      <= PH_SYNC;
            st_q.hold_cnt   <= '0;
            st_q.slot_first <= 1'b1;
            st_q.sel_err    <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    logic unused_b_wrap;
    assign unused_b_wrap = b_wrap;

    assign sync_o        = in_sync;
    assign frame_start_o = st_q.slot_first & in_sync & (st_q.hold_cnt == '0)
                           & (chan_o == CHAN_W'(FIRST_SY));
    assign subcom_adv_o  = tick & (chan_o == CHAN_W'(SUBCOM_CH));
    assign status_rd_o   = (chan_o == CHAN_W'(STATUS_CH_A))
                           | (HAS_STATUS_B & (chan_o == CHAN_W'(STATUS_CH_B)));
    assign sel_err_o     = st_q.sel_err;

endmodule

// File: rtl/tlm_frame_sequencer_chk.sv
module tlm_frame_sequencer_chk #(
    parameter int unsigned N_IN         = 7,
    parameter int unsigned N_GRP        = 5,
    parameter int unsigned SYNC_SLOTS   = 4,
    parameter int unsigned SUBCOM_CH    = 18,
    parameter int unsigned STATUS_CH_A  = 17,
    parameter int unsigned STATUS_CH_B  = 29,
    parameter bit          HAS_STATUS_B = 1'b1,
    parameter int unsigned CHAN_W       = 6
) (
    input logic              clk_i,
    input logic              rst_i,
    input logic              stop_i,
    input logic [N_IN-1:0]   a_sel_o,
    input logic [N_GRP-1:0]  b_sel_o,
    input logic [CHAN_W-1:0] chan_o,
    input logic              sync_o,
    input logic              frame_start_o,
    input logic              subcom_adv_o,
    input logic              status_rd_o,
    input logic              sel_err_o
);

    localparam int unsigned LAST_CH  = N_IN * N_GRP + SYNC_SLOTS - 1;
    localparam int unsigned FIRST_SY = N_IN * N_GRP + 1;

    AST_RESET_STATE: assert property (@(posedge clk_i)
        rst_i |=> (chan_o == CHAN_W'(FIRST_SY)) && (a_sel_o == N_IN'(1)) && (b_sel_o == N_GRP'(1))); // R1

    AST_A_ONEHOT: assert property (@(posedge clk_i) disable iff (rst_i)
        $onehot(a_sel_o)); // R9

    AST_B_ONEHOT: assert property (@(posedge clk_i) disable iff (rst_i)
        $onehot(b_sel_o)); // R9

    AST_NO_SEL_ERR: assert property (@(posedge clk_i) disable iff (rst_i)
        !sel_err_o); // R9

    AST_SYNC_HOLDS_FIRST: assert property (@(posedge clk_i) disable iff (rst_i)
        sync_o |-> (a_sel_o == N_IN'(1)) && (b_sel_o == N_GRP'(1))); // R4

    AST_STOP_FREEZE: assert property (@(posedge clk_i) disable iff (rst_i)
        stop_i |=> $stable(chan_o) && $stable(a_sel_o) && $stable(b_sel_o)); // R8

    AST_STOP_NO_SUBCOM: assert property (@(posedge clk_i) disable iff (rst_i)
        stop_i |-> !subcom_adv_o); // R8

    AST_SUBCOM_SLOT: assert property (@(posedge clk_i) disable iff (rst_i)
        subcom_adv_o |-> chan_o == CHAN_W'(SUBCOM_CH)); // R6

    AST_SUBCOM_ENDS_SLOT: assert property (@(posedge clk_i) disable iff (rst_i)
        subcom_adv_o |=> chan_o == CHAN_W'(SUBCOM_CH + 1)); // R6

    AST_FRAME_START_SLOT: assert property (@(posedge clk_i) disable iff (rst_i)
        frame_start_o |-> sync_o && (chan_o == CHAN_W'(FIRST_SY))); // R5

    AST_FRAME_START_SINGLE: assert property (@(posedge clk_i) disable iff (rst_i)
        frame_start_o |=> !frame_start_o); // R5

    AST_STATUS_SLOT: assert property (@(posedge clk_i) disable iff (rst_i)
        status_rd_o |-> (chan_o == CHAN_W'(STATUS_CH_A))
                        || (HAS_STATUS_B && (chan_o == CHAN_W'(STATUS_CH_B)))); // R7

    AST_CHAN_RANGE: assert property (@(posedge clk_i) disable iff (rst_i)
        (chan_o >= CHAN_W'(1)) && (chan_o <= CHAN_W'(LAST_CH))); // R10

endmodule

bind tlm_frame_sequencer tlm_frame_sequencer_chk #(
    .N_IN         (N_IN),
    .N_GRP        (N_GRP),
    .SYNC_SLOTS   (SYNC_SLOTS),
    .SUBCOM_CH    (SUBCOM_CH),
    .STATUS_CH_A  (STATUS_CH_A),
    .STATUS_CH_B  (STATUS_CH_B),
    .HAS_STATUS_B (HAS_STATUS_B),
    .CHAN_W       (CHAN_W)
) u_chk (
    .clk_i         (clk_i),
    .rst_i         (rst_i),
    .stop_i        (stop_i),
    .a_sel_o       (a_sel_o),
    .b_sel_o       (b_sel_o),
    .chan_o        (chan_o),
    .sync_o        (sync_o),
    .frame_start_o (frame_start_o),
    .subcom_adv_o  (subcom_adv_o),
    .status_rd_o   (status_rd_o),
    .sel_err_o     (sel_err_o)
);

// File: tb/tlm_frame_sequencer_test.sv
module tlm_frame_sequencer_test;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int DIV   = 16;
    localparam int FRAME = 38;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       stop = 1'b0;
    logic [6:0] a_sel;
    logic [4:0] b_sel;
    logic [5:0] chan;
    logic       sync, fstart, subcom, status, selerr;

    int nchk = 0;
    int nfail = 0;
    int mcyc = 0;
    bit prev_stop = 1'b0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    tlm_frame_sequencer #(.DIV(DIV)) uut (
        .clk_i         (clk),
        .rst_i         (rst),
        .stop_i        (stop),
        .a_sel_o       (a_sel),
        .b_sel_o       (b_sel),
        .chan_o        (chan),
        .sync_o        (sync),
        .frame_start_o (fstart),
        .subcom_adv_o  (subcom),
        .status_rd_o   (status),
        .sel_err_o     (selerr)
    );

    function automatic int exp_chan(input int slot);
        int s;
        s = slot % FRAME;
        if (s < 3) return 36 + s;
        if (s == 3) return 1;
        return s - 2;
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s %s actual=%0d expected=%0d (model cycle %0d)", req, what, act, exp, mcyc);
        end
    endtask

    // One clock: drive stop, compare all outputs mid-cycle, then advance the model
    task automatic step(input logic s);
        int slot, ph, ch, pos;
        stop = s;
        #1;
        slot = mcyc / DIV;
        ph   = mcyc % DIV;
        ch   = exp_chan(slot);
        pos  = (ch == 1 || ch >= 36) ? 0 : ch - 1;
        chk("R10", "chan", int'(chan), ch);
        chk("R3", "a_sel", int'(a_sel), 1 << (pos % 7));
        chk("R3", "b_sel", int'(b_sel), 1 << (pos / 7));
        chk("R4", "sync", int'(sync), (pos == 0) ? 1 : 0);
        chk("R5", "frame_start", int'(fstart), (ph == 0 && ch == 36 && !prev_stop) ? 1 : 0);
        chk("R6", "subcom_adv", int'(subcom), (!s && ph == DIV - 1 && ch == 18) ? 1 : 0);
        chk("R7", "status_rd", int'(status), (ch == 17 || ch == 29) ? 1 : 0);
        chk("R9", "sel_err", int'(selerr), 0);
        @(negedge clk);
        prev_stop = s;
        if (!s) mcyc++;
    endtask

    task automatic run(input int n, input logic s);
        for (int i = 0; i < n; i++) step(s);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        stop = 1'b0;
        repeat (2) @(negedge clk);
        #1;
        chk("R1", "chan in reset", int'(chan), 36);
        chk("R1", "a_sel in reset", int'(a_sel), 1);
        chk("R1", "b_sel in reset", int'(b_sel), 1);
        chk("R1", "sync in reset", int'(sync), 1);
        chk("R1", "sel_err in reset", int'(selerr), 0);
        @(negedge clk);
        rst = 1'b0;
        mcyc = 0;
        prev_stop = 1'b0;
    endtask

    // R1 R5: reset values and first-cycle frame start
    task automatic t_reset_state();
        do_reset();
        #1;
        chk("R1", "frame_start after release", int'(fstart), 1);
        @(negedge clk);
        #1;
        chk("R5", "frame_start second cycle", int'(fstart), 0);
        do_reset();
    endtask

    // R2 R3 R4 R5 R6 R7 R10: two whole frames plus a few cycles
    task automatic t_two_frames();
        do_reset();
        run(2 * FRAME * DIV + 5, 1'b0);
    endtask

    // R8: stop in the middle of channel 10
    task automatic t_stop_mid();
        do_reset();
        run(12 * DIV + 5, 1'b0);
        run(40, 1'b1);
        run(FRAME * DIV, 1'b0);
    endtask

    // R6 R8: stop on the last clock of channel 18, pulse only on release
    task automatic t_stop_subcom();
        do_reset();
        run(20 * DIV + DIV - 1, 1'b0);
        run(30, 1'b1);
        run(2 * DIV, 1'b0);
    endtask

    // R4 R5 R8: stop at the very first sync clock
    task automatic t_stop_sync();
        do_reset();
        run(10, 1'b1);
        run(6 * DIV, 1'b0);
    endtask

    // R1: reset in mid-frame returns to channel 36
    task automatic t_reset_midframe();
        do_reset();
        run(25 * DIV + 3, 1'b0);
        do_reset();
        run(3 * DIV, 1'b0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    endtask

    initial begin
        t_reset_state();
        t_two_frames();
        t_stop_mid();
        t_stop_subcom();
        t_stop_sync();
        t_reset_midframe();
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=done");
        finish_run();
    end

endmodule